// File: doc/BRIEF.md
# Zero-Page Bit Operation Sequencer

This unit executes three instruction kinds of an 8-bit accumulator CPU: plain conditional relative branches, single-bit set or clear of a byte in the direct page, and a combined test of one direct-page bit followed by a relative branch. It owns the 16-bit program counter and the carry flag. It drives its own memory cycles: a read strobe with an address, read data one cycle later, and a write strobe with data.

The surrounding decoder presents an opcode with a one-cycle `start` strobe while the program counter points at that opcode. For plain branches the decoder evaluates the condition itself and supplies it on `branchTaken` in the same cycle. The unit fetches the operand bytes that follow the opcode and performs any direct-page read-modify-write. It then updates the program counter, and the carry flag where that applies, and reports completion with a one-cycle `done` pulse.

Top module: `zp_bit_seq`

## Requirements
- R1: Opcode decode uses the upper nibble. 0x0 selects test-and-branch, which branches when the bit is set if opcode bit 0 is 0 and when it is clear if bit 0 is 1. 0x1 selects bit modify, which sets the bit if opcode bit 0 is 0 and clears it if bit 0 is 1. 0x2 selects a plain relative branch. The bit number is opcode[3:1]. Any other upper nibble is ignored: there is no memory cycle and no `done`, and PC and carry are unchanged.
- R2: A plain branch reads a signed offset from PC+1. If `branchTaken` was high with `start`, PC becomes PC+2 plus the sign-extended offset; otherwise PC becomes PC+2. The reach is −126 to +129 bytes from the opcode, and carry is unchanged.
- R3: Bit modify reads the byte at the direct address held at PC+1 and writes it back to the same address with only the selected bit changed. PC becomes PC+2 and carry is unchanged.
- R4: Test-and-branch reads the direct address at PC+1 and a signed offset at PC+2. When its condition holds, PC becomes PC+3 plus the sign-extended offset; otherwise PC becomes PC+3. The reach is −125 to +130 from the opcode, and `branchTaken` is ignored.
- R5: Test-and-branch copies the tested bit into carry whether or not it branches.
- R6: Every direct-page access drives address bits [15:8] to zero and bits [7:0] to the operand byte.
- R7: PC arithmetic wraps modulo 2^16 in both directions.
- R8: Read data is taken one cycle after the address cycle. Reads and writes never coincide. `done` lasts exactly one cycle and rises 3, 6 and 7 clock edges after the accepting edge for plain branch, bit modify and test-and-branch. PC and carry change only at the edge that raises `done`.
- R9: A `start` that arrives while an instruction is in progress is ignored. A `start` that arrives in the `done` cycle is accepted and runs from the updated PC.
- R10: Asynchronous reset (`rstN` low) sets PC to `RESET_PC` (default 0x0000) and clears carry, `done` and both memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opcode strobe, one cycle |
| opcode | input | 8 | Opcode at the current PC, valid with `start` |
| branchTaken | input | 1 | Plain-branch condition, valid with `start` |
| memAddr | output | 16 | Memory address |
| memRdEn | output | 1 | Read strobe; data returns next cycle |
| memRdData | input | 8 | Read data |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 8 | Write data |
| pc | output | 16 | Program counter |
| carry | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle. The first is the completion pulse of one instruction together with the strobe for the next, where the new instruction must see the already updated PC. The bench raises `start` in the very cycle it observes `done`. It then checks that the follow-on branch lands relative to the new PC and finishes three edges later. The second is a strobe arriving mid-instruction. The bench issues a plain taken branch two cycles into a test-and-branch and checks that only the test-and-branch result appears, with no second `done` afterwards.

// File: rtl/zp_bit_seq_pkg.sv
package zp_bit_seq_pkg;

  localparam int OPCODE_W = 8;

  typedef enum logic [1:0] {
    KIND_TEST = 2'd0,
    KIND_BIT  = 2'd1,
    KIND_REL  = 2'd2,
    KIND_NONE = 2'd3
  } instrKind_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_OPND,
    BUS_OFFS,
    BUS_PAGE
  } busSel_e;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_REL,
    PC_BITOP,
    PC_TEST
  } pcUpd_e;

  typedef struct packed {
    logic    capOpcode;
    logic    rdEn;
    logic    wrEn;
    busSel_e busSel;
    logic    capOpnd;
    logic    capOffs;
    logic    capByte;
    pcUpd_e  pcUpd;
  } seqCtl_t;

  function automatic instrKind_e decodeKind(input logic [OPCODE_W-1:0] op);
    case (op[OPCODE_W-1:4])
      4'h0:    return KIND_TEST;
      4'h1:    return KIND_BIT;
      4'h2:    return KIND_REL;
      default: return KIND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/zp_bit_seq_ctrl.sv
module zp_bit_seq_ctrl
  import zp_bit_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  instrKind_e kindNow,
  output seqCtl_t    ctl,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_A_OPND, S_D_OPND, S_A_OFFS, S_D_OFFS,
    S_A_PAGE, S_D_PAGE, S_WR_PAGE, S_FIN
  } seqState_e;

  seqState_e  state, stateNxt;
  instrKind_e kindReg;
  logic       accept;

  assign accept = start && (state == S_IDLE || state == S_FIN) && (kindNow != KIND_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindReg <= KIND_NONE;
    end else begin
      state <= stateNxt;
      if (accept) kindReg <= kindNow;
    end
  end

  always_comb begin
    ctl      = '0;
    done     = 1'b0;
    stateNxt = state;
    case (state)
      S_IDLE, S_FIN: begin
        done = (state == S_FIN);
        if (accept) begin
          ctl.capOpcode = 1'b1;
          stateNxt      = S_A_OPND;
        end else begin
          stateNxt = S_IDLE;
        end
      end
      S_A_OPND: begin
        ctl.rdEn   = 1'b1;
        ctl.busSel = BUS_OPND;
        stateNxt   = S_D_OPND;
      end
      S_D_OPND: begin
        if (kindReg == KIND_REL) begin
          ctl.pcUpd = PC_REL;
          stateNxt  = S_FIN;
        end else begin
          ctl.capOpnd = 1'b1;
          stateNxt    = (kindReg == KIND_TEST) ? S_A_OFFS : S_A_PAGE;
        end
      end
      S_A_OFFS: begin
        ctl.rdEn   = 1'b1;
        ctl.busSel = BUS_OFFS;
        stateNxt   = S_D_OFFS;
      end
      S_D_OFFS: begin
        ctl.capOffs = 1'b1;
        stateNxt    = S_A_PAGE;
      end
      S_A_PAGE: begin
        ctl.rdEn   = 1'b1;
        ctl.busSel = BUS_PAGE;
        stateNxt   = S_D_PAGE;
      end
      S_D_PAGE: begin
        if (kindReg == KIND_TEST) begin
          ctl.pcUpd = PC_TEST;
          stateNxt  = S_FIN;
        end else begin
          ctl.capByte = 1'b1;
          stateNxt    = S_WR_PAGE;
        end
      end
      S_WR_PAGE: begin
        ctl.wrEn   = 1'b1;
        ctl.busSel = BUS_PAGE;
        ctl.pcUpd  = PC_BITOP;
        stateNxt   = S_FIN;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: never a read and a write together
  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rdEn && ctl.wrEn));

  // R1: an unknown opcode leaves the sequencer idle
  a_r1_unknown_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && kindNow == KIND_NONE && state == S_IDLE) |=> (state == S_IDLE && !ctl.rdEn));

  // R9: a strobe mid-instruction never restarts the sequence
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_FIN) |=> state != S_A_OPND);

endmodule

// File: rtl/zp_bit_seq_dp.sv
module zp_bit_seq_dp
  import zp_bit_seq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic [OPCODE_W-1:0] opcodeIn,
  input  logic                takenIn,
  input  logic [DATA_W-1:0]   rdData,
  output instrKind_e          kindNow,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [ADDR_W-1:0]   pcOut,
  output logic                carryOut
);

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int PAGE_PAD = ADDR_W - DATA_W;

  logic [IDX_W:0]      opReg;
  logic                takenReg;
  logic [DATA_W-1:0]   opndReg, offsReg, byteReg;
  logic [ADDR_W-1:0]   pcReg, pcNext;
  logic                carryReg;
  logic [IDX_W-1:0]    bitIdx;
  logic                clrSel, testedBit, testHit;

  function automatic logic [ADDR_W-1:0] sext(input logic [DATA_W-1:0] v);
    return {{PAGE_PAD{v[DATA_W-1]}}, v};
  endfunction

  assign kindNow   = decodeKind(opcodeIn);
  assign bitIdx    = opReg[IDX_W:1];
  assign clrSel    = opReg[0];
  assign testedBit = rdData[bitIdx];
  assign testHit   = testedBit ^ clrSel;

  always_comb begin
    case (ctl.pcUpd)
      PC_REL:   pcNext = pcReg + ADDR_W'(2) + (takenReg ? sext(rdData) : '0);
      PC_BITOP: pcNext = pcReg + ADDR_W'(2);
      PC_TEST:  pcNext = pcReg + ADDR_W'(3) + (testHit ? sext(offsReg) : '0);
      default:  pcNext = pcReg;
    endcase
  end

  always_comb begin
    case (ctl.busSel)
      BUS_OPND: busAddr = pcReg + ADDR_W'(1);
      BUS_OFFS: busAddr = pcReg + ADDR_W'(2);
      BUS_PAGE: busAddr = {{PAGE_PAD{1'b0}}, opndReg};
      default:  busAddr = '0;
    endcase
  end

  always_comb begin
    wrData         = byteReg;
    wrData[bitIdx] = ~clrSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= '0;
      takenReg <= 1'b0;
      opndReg  <= '0;
      offsReg  <= '0;
      byteReg  <= '0;
      pcReg    <= RESET_PC;
      carryReg <= 1'b0;
    end else begin
      if (ctl.capOpcode) begin
        opReg    <= opcodeIn[IDX_W:0];
        takenReg <= takenIn;
      end
      if (ctl.capOpnd) opndReg <= rdData;
      if (ctl.capOffs) offsReg <= rdData;
      if (ctl.capByte) byteReg <= rdData;
      if (ctl.pcUpd == PC_TEST) carryReg <= testedBit;
      pcReg <= pcNext;
    end
  end

  assign pcOut    = pcReg;
  assign carryOut = carryReg;

  // R6: direct-page reads and writes stay in the first page
  a_r6_page_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.rdEn && ctl.busSel == BUS_PAGE) || ctl.wrEn) |-> busAddr[ADDR_W-1:DATA_W] == '0);

  // R3: write-back differs from the byte read by at most one bit
  a_r3_single_bit_change: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> $onehot0(wrData ^ $past(rdData)));

  // R3: write-back goes to the address that was read
  a_r3_write_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> busAddr == $past(busAddr, 2));

endmodule

// File: rtl/zp_bit_seq.sv
module zp_bit_seq
  import zp_bit_seq_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [OPCODE_W-1:0] opcode,
  input  logic                branchTaken,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRdEn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [DATA_W-1:0]   memWrData,
  output logic [ADDR_W-1:0]   pc,
  output logic                carry,
  output logic                done
);

  seqCtl_t    ctl;
  instrKind_e kindNow;

  zp_bit_seq_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .kindNow (kindNow),
    .ctl     (ctl),
    .done    (done)
  );

  zp_bit_seq_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opcodeIn (opcode),
    .takenIn  (branchTaken),
    .rdData   (memRdData),
    .kindNow  (kindNow),
    .busAddr  (memAddr),
    .wrData   (memWrData),
    .pcOut    (pc),
    .carryOut (carry)
  );

  assign memRdEn = ctl.rdEn;
  assign memWrEn = ctl.wrEn;

  // R8: PC moves only at the edge that raises done
  a_r8_pc_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (pc != $past(pc)) |-> done);

  // R5: carry moves only at the edge that raises done
  a_r5_carry_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (carry != $past(carry)) |-> done);

endmodule

// File: tb/zp_bit_seq_test.sv
`timescale 1ns/1ps
module zp_bit_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        branchTaken = 1'b0;
  logic [15:0] memAddr;
  logic        memRdEn;
  logic [7:0]  memRdData = 8'h00;
  logic        memWrEn;
  logic [7:0]  memWrData;
  logic [15:0] pc;
  logic        carry;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  zp_bit_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .branchTaken(branchTaken),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .pc(pc), .carry(carry), .done(done)
  );

  // memory model: operand bytes follow curPc, one direct-page byte at b1
  logic [15:0] curPc = 16'h0000;
  logic [7:0]  b1 = 8'h00, b2 = 8'h00, zp = 8'h00;
  int          rdCount = 0, wrCount = 0;
  logic [15:0] wrAddrSeen = 16'h0;
  logic [7:0]  wrDataSeen = 8'h0;
  logic [15:0] pcP1, pcP2;
  assign pcP1 = curPc + 16'd1;
  assign pcP2 = curPc + 16'd2;

  always @(posedge clk) begin
    if (memRdEn) begin
      rdCount <= rdCount + 1;
      if (memAddr == pcP1)              memRdData <= b1;
      else if (memAddr == pcP2)         memRdData <= b2;
      else if (memAddr == {8'h00, b1})  memRdData <= zp;
      else                              memRdData <= 8'hA5;
    end
    if (memWrEn) begin
      wrCount    <= wrCount + 1;
      wrAddrSeen <= memAddr;
      wrDataSeen <= memWrData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic tk);
    @(negedge clk);
    start = 1'b1; opcode = op; branchTaken = tk;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R8", "done timeout", 32'(done), 32'd1);
  endtask

  // {opcode, byte1, byte2, directByte, taken, expByte, expCarry, pcDelta}
  localparam int NV = 13;
  localparam logic [71:0] VEC [NV] = '{
    {8'h20, 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 16'hFF82}, // R2 R7 -126 reach, wraps down
    {8'h20, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0002}, // R2 not taken
    {8'h16, 8'h40, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 16'h0002}, // R3 set bit3
    {8'h1F, 8'h41, 8'h00, 8'hFF, 8'h01, 8'h7F, 8'h00, 16'h0002}, // R3 clear bit7
    {8'h10, 8'h42, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 16'h0002}, // R3 set already-set bit0
    {8'h0A, 8'h43, 8'h05, 8'h20, 8'h00, 8'h00, 8'h01, 16'h0008}, // R4 R5 on-set taken
    {8'h0B, 8'h43, 8'h40, 8'h20, 8'h01, 8'h00, 8'h01, 16'h0003}, // R4 on-clear not taken
    {8'h05, 8'h44, 8'h80, 8'hFB, 8'h00, 8'h00, 8'h00, 16'hFF83}, // R4 -125 reach
    {8'h02, 8'h45, 8'h7F, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0003}, // R4 taken input ignored
    {8'h20, 8'h7F, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0081}, // R2 +129 reach
    {8'h0E, 8'h46, 8'h7F, 8'h80, 8'h00, 8'h00, 8'h01, 16'h0082}, // R4 R7 +130, wraps up
    {8'h11, 8'h47, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 16'h0002}, // R3 clear bit0, carry kept
    {8'h20, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 16'h0002}  // R2 carry kept
  };

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R8 watchdog expired: actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int w0, r0;
    logic [15:0] expPc;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(pc == 16'h0000, "R10", "reset pc", 32'(pc), 32'h0);
    check(carry == 1'b0, "R10", "reset carry", 32'(carry), 32'h0);
    check(!done && !memRdEn && !memWrEn, "R10", "reset strobes",
          32'({done, memRdEn, memWrEn}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  op, eb;
      logic        tk, ec;
      logic [15:0] dl;
      int          expLat;
      string       tag;
      {op, b1, b2, zp} = VEC[i][71:40];
      tk = VEC[i][32];
      eb = VEC[i][31:24];
      ec = VEC[i][16];
      dl = VEC[i][15:0];
      expPc  = curPc + dl;
      expLat = (op[7:4] == 4'h2) ? 3 : (op[7:4] == 4'h1) ? 6 : 7;
      tag    = (op[7:4] == 4'h2) ? "R2" : (op[7:4] == 4'h1) ? "R3" : "R4";
      if ((!dl[15] && expPc < curPc) || (dl[15] && expPc > curPc)) tag = "R7";
      w0 = wrCount;
      issue(op, tk);
      waitDone(lat);
      check(lat == expLat, "R8", "latency", 32'(lat), 32'(expLat));
      check(pc == expPc, tag, "pc", 32'(pc), 32'(expPc));
      check(carry == ec, (op[7:4] == 4'h0) ? "R5" : tag, "carry", 32'(carry), 32'(ec));
      if (op[7:4] == 4'h1) begin
        check(wrCount - w0 == 1, "R3", "write count", 32'(wrCount - w0), 32'd1);
        check(wrAddrSeen == {8'h00, b1}, "R6", "write address", 32'(wrAddrSeen), 32'({8'h00, b1}));
        check(wrDataSeen == eb, "R3", "written byte", 32'(wrDataSeen), 32'(eb));
      end else begin
        check(wrCount == w0, tag, "no write", 32'(wrCount - w0), 32'd0);
      end
      @(negedge clk);
      check(!done, "R8", "done width", 32'(done), 32'd0);
      curPc = expPc;
    end

    // R9: strobe mid-instruction ignored (pc 0x0022, carry 1)
    b1 = 8'h48; b2 = 8'h10; zp = 8'h00;
    issue(8'h00, 1'b0);
    @(negedge clk);
    start = 1'b1; opcode = 8'h20; branchTaken = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 7, "R9", "latency with stray strobe", 32'(lat), 32'd7);
    check(pc == 16'h0025, "R9", "pc with stray strobe", 32'(pc), 32'h0025);
    check(carry == 1'b0, "R5", "carry tested clear", 32'(carry), 32'h0);
    curPc = 16'h0025;
    repeat (6) begin
      @(negedge clk);
      check(!done, "R9", "no ghost done", 32'(done), 32'd0);
    end

    // R9: new strobe in the done cycle
    b1 = 8'h10;
    issue(8'h20, 1'b1);
    waitDone(lat);
    check(pc == 16'h0037, "R2", "first of pair", 32'(pc), 32'h0037);
    curPc = 16'h0037; b1 = 8'h33;
    start = 1'b1; opcode = 8'h20; branchTaken = 1'b0;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    check(lat == 3, "R9", "back-to-back latency", 32'(lat), 32'd3);
    check(pc == 16'h0039, "R9", "back-to-back pc", 32'(pc), 32'h0039);
    curPc = 16'h0039;

    // R1: unknown opcode ignored
    r0 = rdCount;
    issue(8'h35, 1'b1);
    repeat (8) begin
      check(!done, "R1", "no done on unknown", 32'(done), 32'd0);
      @(negedge clk);
    end
    check(rdCount == r0, "R1", "no read on unknown", 32'(rdCount - r0), 32'd0);
    check(pc == 16'h0039, "R1", "pc kept on unknown", 32'(pc), 32'h0039);

    // R10: reset mid-instruction
    b1 = 8'h49; zp = 8'h00;
    issue(8'h0E, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(pc == 16'h0000 && carry == 1'b0, "R10", "async reset pc/carry",
          32'({pc, 3'b0, carry}), 32'h0);
    check(!memRdEn && !memWrEn && !done, "R10", "async reset strobes",
          32'({done, memRdEn, memWrEn}), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    curPc = 16'h0000;
    @(negedge clk);
    check(!done && pc == 16'h0000, "R10", "idle after reset", 32'(pc), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule